// File: doc/BRIEF.md
# GPIO Pin Function and Output Control

This block holds the configuration that turns each line of a general-purpose I/O port into one of eight roles: a plain input, a software-driven output, or one of six alternate functions supplied by other on-chip peripherals. Every pin has a 3-bit function code. Codes are packed ten to a 32-bit register. A single output data latch per pin holds the value the pin drives while it is a plain output.

Software never rewrites the latch word directly. It writes a 1 to a bit of a set register to raise that pin's latch, or a 1 to a bit of a clear register to lower it. Both register kinds are write-only. Because set and clear are separate registers, software does not need a read-modify-write sequence. The latch follows these writes even while the pin is an input. When the pin is later made an output, it drives the value of the most recent set or clear.

The pin side gives three outputs per pin: an output enable, the output value, and the selected alternate-function signal. Each pin has six alternate-function inputs. Alternate slots that have nothing wired to them are listed in a parameter mask and read as constant 0. Register reads are combinational and return data in the same cycle as the request.

Top module: `gpio_fn_ctrl`

## Requirements
- R1: After reset, every function code is 000 and every output latch is 0. Every pin then has pin_oe_o=0, pin_out_o=0 and pin_alt_o=0, and every function register reads 0.
- R2: Pin p's code lives in the function register at byte offset 4*(p/10), in bits [3*(p%10)+2 : 3*(p%10)]. A write stores the fields and a read returns them. Bits 31:30 read 0, and so do fields of pins at or above NUM_PINS; writes to these bits are dropped.
- R3: Code 000 (input) gives oe=0, out=0 and alt=0. Code 001 (output) gives oe=1 with out equal to the pin's latch and alt=0.
- R4: Codes 100, 101, 110 and 111 select alternates 0 to 3, code 011 selects alternate 4, and code 010 selects alternate 5. Alternate a of pin p is input bit alt_func_i[6*p+a]. While an alternate is selected, oe=1 and both out and alt equal that input.
- R5: An alternate slot whose bit in ALT_PRESENT is 0 drives 0 on out and alt whatever its input does, with oe still 1.
- R6: The set registers sit at offset 0x1C (pins 0-31, bit p) and 0x20 (pins 32 and up, bit p-32). A 1 bit sets that pin's latch; a 0 bit leaves it unchanged.
- R7: The clear registers sit at offset 0x28 (pins 0-31) and 0x2C (pins 32 and up). A 1 bit clears that pin's latch; a 0 bit leaves it unchanged.
- R8: Set and clear writes to a pin in input mode leave its outputs at 0 but still update the latch. Switching the pin to output then drives the latch value.
- R9: Reads of the set and clear offsets, and of any unmapped offset, return 0. Writes to unmapped or unaligned offsets change no state.
- R10: With bus_req_i low, no write takes effect whatever bus_we_i, bus_addr_i and bus_wdata_i carry, and bus_rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the request |
| alt_func_i | input | NUM_PINS*6 | Alternate-function signals, six per pin |
| pin_oe_o | output | NUM_PINS | Per-pin output enable |
| pin_out_o | output | NUM_PINS | Per-pin driven value |
| pin_alt_o | output | NUM_PINS | Per-pin selected alternate-function signal |

## Verification
The bench builds the block with NUM_PINS=58. With that width the last function register is only partly filled (pins 50-57) and the upper set and clear registers are 26 bits wide. The masking of unused fields and bits is therefore exercised. ALT_PRESENT is a computed mask with scattered zeros, so every function code meets both wired and unwired alternate slots, and the rule that an unwired slot drives 0 is observable. Random writes to arbitrary byte offsets also reach the reserved gaps and unaligned addresses.

// File: rtl/gpio_fn_pkg.sv
package gpio_fn_pkg;
  localparam int unsigned BUS_W        = 32;
  localparam int unsigned FN_W         = 3;
  localparam int unsigned FN_PER_WORD  = 10;
  localparam int unsigned ALT_CNT      = 6;
  localparam int unsigned WORD_BYTES   = 4;
  localparam int unsigned OFS_SET0     = 'h1C;
  localparam int unsigned OFS_CLR0     = 'h28;

  typedef enum logic [FN_W-1:0] {
    FN_INPUT  = 3'b000,
    FN_OUTPUT = 3'b001,
    FN_ALT5   = 3'b010,
    FN_ALT4   = 3'b011,
    FN_ALT0   = 3'b100,
    FN_ALT1   = 3'b101,
    FN_ALT2   = 3'b110,
    FN_ALT3   = 3'b111
  } fn_code_e;

  // Maps a non-binary alternate code to its slot number.
  function automatic logic [2:0] alt_slot(input logic [FN_W-1:0] code);
    case (code)
      FN_ALT0: alt_slot = 3'd0;
      FN_ALT1: alt_slot = 3'd1;
      FN_ALT2: alt_slot = 3'd2;
      FN_ALT3: alt_slot = 3'd3;
      FN_ALT4: alt_slot = 3'd4;
      FN_ALT5: alt_slot = 3'd5;
      default: alt_slot = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
  import gpio_fn_pkg::*;
#(
  parameter int unsigned NUM_PINS = 58,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [BUS_W-1:0]         wdata_i,
  output logic [BUS_W-1:0]         rdata_o,
  output logic [NUM_PINS*FN_W-1:0] fsel_o
);
  localparam int unsigned NUM_WORDS = (NUM_PINS + FN_PER_WORD - 1) / FN_PER_WORD;

  logic [NUM_PINS*FN_W-1:0] fsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsel_q <= '0;
    end else if (wr_i) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (addr_i == ADDR_W'((p / FN_PER_WORD) * WORD_BYTES))
          fsel_q[p*FN_W +: FN_W] <= wdata_i[(p % FN_PER_WORD)*FN_W +: FN_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr_i == ADDR_W'((p / FN_PER_WORD) * WORD_BYTES))
        rdata_o[(p % FN_PER_WORD)*FN_W +: FN_W] = fsel_q[p*FN_W +: FN_W];
    end
  end

  assign fsel_o = fsel_q;

  logic unused_words;
  assign unused_words = (NUM_WORDS == 0);
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_fn_pkg::*;
#(
  parameter int unsigned NUM_PINS = 58,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [NUM_PINS-1:0] latch_o
);
  logic [NUM_PINS-1:0] set_v, clr_v, latch_q;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      set_v[p] = wr_i && wdata_i[p % BUS_W] &&
                 (addr_i == ADDR_W'(OFS_SET0 + (p / BUS_W) * WORD_BYTES));
      clr_v[p] = wr_i && wdata_i[p % BUS_W] &&
                 (addr_i == ADDR_W'(OFS_CLR0 + (p / BUS_W) * WORD_BYTES));
    end
  end

  // Clear wins if both reach a pin together.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= (latch_q | set_v) & ~clr_v;
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/gpio_pin_sel.sv
module gpio_pin_sel
  import gpio_fn_pkg::*;
#(
  parameter logic [ALT_CNT-1:0] PRESENT = '1
) (
  input  logic [FN_W-1:0]    code_i,
  input  logic               latch_i,
  input  logic [ALT_CNT-1:0] alt_i,
  output logic               oe_o,
  output logic               out_o,
  output logic               alt_o
);
  logic [ALT_CNT-1:0] avail;
  logic               alt_bit;

  assign avail   = alt_i & PRESENT;
  assign alt_bit = avail[alt_slot(code_i)];

  always_comb begin
    case (code_i)
      FN_INPUT: begin
        oe_o = 1'b0; out_o = 1'b0; alt_o = 1'b0;
      end
      FN_OUTPUT: begin
        oe_o = 1'b1; out_o = latch_i; alt_o = 1'b0;
      end
      default: begin
        oe_o = 1'b1; out_o = alt_bit; alt_o = alt_bit;
      end
    endcase
  end
endmodule

// File: rtl/gpio_fn_ctrl.sv
module gpio_fn_ctrl
  import gpio_fn_pkg::*;
#(
  parameter int unsigned NUM_PINS = 58,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [NUM_PINS*ALT_CNT-1:0] ALT_PRESENT = '1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_req_i,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [BUS_W-1:0]            bus_wdata_i,
  output logic [BUS_W-1:0]            bus_rdata_o,
  input  logic [NUM_PINS*ALT_CNT-1:0] alt_func_i,
  output logic [NUM_PINS-1:0]         pin_oe_o,
  output logic [NUM_PINS-1:0]         pin_out_o,
  output logic [NUM_PINS-1:0]         pin_alt_o
);
  logic                     wr;
  logic [BUS_W-1:0]         fsel_rdata;
  logic [NUM_PINS*FN_W-1:0] fsel;
  logic [NUM_PINS-1:0]      out_latch;

  assign wr = bus_req_i && bus_we_i;

  gpio_fsel_bank #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_fsel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (fsel_rdata),
    .fsel_o  (fsel)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .latch_o (out_latch)
  );

  // Set/clear offsets are write-only: only function words reach the read path.
  assign bus_rdata_o = (bus_req_i && !bus_we_i) ? fsel_rdata : '0;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_sel #(.PRESENT(ALT_PRESENT[p*ALT_CNT +: ALT_CNT])) i_sel (
      .code_i  (fsel[p*FN_W +: FN_W]),
      .latch_i (out_latch[p]),
      .alt_i   (alt_func_i[p*ALT_CNT +: ALT_CNT]),
      .oe_o    (pin_oe_o[p]),
      .out_o   (pin_out_o[p]),
      .alt_o   (pin_alt_o[p])
    );
  end
endmodule

// File: rtl/gpio_fn_ctrl_chk.sv
module gpio_fn_ctrl_chk
  import gpio_fn_pkg::*;
#(
  parameter int unsigned NUM_PINS = 58,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_req_i,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [BUS_W-1:0]    bus_wdata_i,
  input logic [BUS_W-1:0]    bus_rdata_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_PINS-1:0] pin_out_o,
  input logic [NUM_PINS-1:0] pin_alt_o,
  input logic [NUM_PINS-1:0] latch_q
);
  logic [NUM_PINS-1:0] set_hit, clr_hit;
  logic                wr, rd_setclr;

  assign wr = bus_req_i && bus_we_i;
  assign rd_setclr = bus_req_i && !bus_we_i &&
    (bus_addr_i == ADDR_W'(OFS_SET0) || bus_addr_i == ADDR_W'(OFS_SET0 + WORD_BYTES) ||
     bus_addr_i == ADDR_W'(OFS_CLR0) || bus_addr_i == ADDR_W'(OFS_CLR0 + WORD_BYTES));

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      set_hit[p] = wr && bus_wdata_i[p % BUS_W] &&
                   bus_addr_i == ADDR_W'(OFS_SET0 + (p / BUS_W) * WORD_BYTES);
      clr_hit[p] = wr && bus_wdata_i[p % BUS_W] &&
                   bus_addr_i == ADDR_W'(OFS_CLR0 + (p / BUS_W) * WORD_BYTES);
    end
  end

  AST_UNDRIVEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~pin_oe_o) == '0); // R3
  AST_ALT_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_alt_o & ~pin_oe_o) == '0); // R4
  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_hit != '0) |=> ((latch_q & $past(set_hit)) == $past(set_hit))); // R6
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit != '0) |=> ((latch_q & $past(clr_hit)) == '0)); // R7
  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(latch_q)); // R10
  AST_SETCLR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_setclr |-> bus_rdata_o == '0); // R9
endmodule

bind gpio_fn_ctrl gpio_fn_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pin_oe_o    (pin_oe_o),
  .pin_out_o   (pin_out_o),
  .pin_alt_o   (pin_alt_o),
  .latch_q     (out_latch)
);

// File: tb/test_gpio_fn_ctrl.sv
`timescale 1ns/1ps
module test_gpio_fn_ctrl;
  localparam int NP = 58;
  localparam int AW = 8;
  localparam int NA = 6;

  function automatic logic [NP*NA-1:0] mk_mask();
    logic [NP*NA-1:0] m;
    for (int i = 0; i < NP*NA; i++) m[i] = ((i * 7) % 11) != 0;
    return m;
  endfunction
  localparam logic [NP*NA-1:0] MASK = mk_mask();

  logic            clk = 0;
  logic            rst_n = 0;
  logic            req = 0, we = 0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NP*NA-1:0] alt_v = '0;
  logic [NP-1:0]   oe, out, alt;

  logic [2:0]    m_fn [NP];
  logic [NP-1:0] m_lat;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_fn_ctrl #(.NUM_PINS(NP), .ADDR_W(AW), .ALT_PRESENT(MASK)) i_gpio_fn_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .alt_func_i(alt_v), .pin_oe_o(oe), .pin_out_o(out), .pin_alt_o(alt)
  );

  // Slot number for a code, -1 for input/output (R4 encoding).
  function automatic int slot_of(logic [2:0] c);
    case (c)
      3'b100: return 0; 3'b101: return 1; 3'b110: return 2;
      3'b111: return 3; 3'b011: return 4; 3'b010: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [3*NP-1:0] exp_pins();
    logic [NP-1:0] e_oe, e_out, e_alt;
    for (int p = 0; p < NP; p++) begin
      int s;
      s = slot_of(m_fn[p]);
      if (m_fn[p] == 3'b000) begin e_oe[p]=0; e_out[p]=0; e_alt[p]=0; end
      else if (m_fn[p] == 3'b001) begin e_oe[p]=1; e_out[p]=m_lat[p]; e_alt[p]=0; end
      else begin
        e_oe[p] = 1;
        e_out[p] = alt_v[p*NA+s] & MASK[p*NA+s];
        e_alt[p] = e_out[p];
      end
    end
    return {e_oe, e_out, e_alt};
  endfunction

  function automatic logic [31:0] exp_read(logic [AW-1:0] a);
    logic [31:0] r = '0;
    for (int p = 0; p < NP; p++)
      if (a == AW'((p / 10) * 4)) r[(p % 10)*3 +: 3] = m_fn[p];
    return r;
  endfunction

  function automatic void model_write(logic [AW-1:0] a, logic [31:0] d);
    for (int p = 0; p < NP; p++) begin
      if (a == AW'((p / 10) * 4)) m_fn[p] = d[(p % 10)*3 +: 3];
      if (a == AW'(8'h1C + (p / 32) * 4) && d[p % 32]) m_lat[p] = 1'b1;
      if (a == AW'(8'h28 + (p / 32) * 4) && d[p % 32]) m_lat[p] = 1'b0;
    end
  endfunction

  task automatic check_pins(string tag);
    logic [3*NP-1:0] e, act;
    e = exp_pins();
    act = {oe, out, alt};
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s pins: actual=%h expected=%h", tag, act, e);
    end
  endtask

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] e);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, e);
    end
  endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0;
    model_write(a, d);
    #1;
  endtask

  task automatic bus_rd(logic [AW-1:0] a, string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #2;
    check_val(tag, rdata, exp_read(a));
    @(negedge clk);
    req = 0;
  endtask

  task automatic set_alt_random();
    @(negedge clk);
    for (int i = 0; i < NP*NA; i++) alt_v[i] = 1'($urandom);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int p = 0; p < NP; p++) m_fn[p] = 3'b000;
    m_lat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // R1: reset state
    check_pins("R1 reset");
    for (int r = 0; r < 6; r++) bus_rd(AW'(r*4), "R1 fsel reset read");

    // R2: packing and reserved bits
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h00, "R2 reserved 31:30 read 0");
    check_val("R2 full word0", exp_read(8'h00), 32'h3FFF_FFFF);
    bus_wr(8'h14, 32'hFFFF_FFFF);
    bus_rd(8'h14, "R2 partial last word");
    check_val("R2 last word fields", exp_read(8'h14), 32'h00FF_FFFF);
    bus_wr(8'h0C, 32'h2A5C_3E91);
    bus_rd(8'h0C, "R2 word3 pattern");

    // R3/R4/R5: every code on many pins against varied alternate inputs
    for (int it = 0; it < 8; it++) begin
      for (int r = 0; r < 6; r++) begin
        logic [31:0] d = '0;
        for (int k = 0; k < 10; k++) d[k*3 +: 3] = 3'((k + r + it) % 8);
        bus_wr(AW'(r*4), d);
      end
      set_alt_random();
      check_pins("R4 R5 code sweep");
      alt_v = '1; #1;
      check_pins("R5 unwired slots stay 0");
      alt_v = '0; #1;
      check_pins("R3 R4 alternates low");
    end

    // R8: set/clear while input, then switch to output
    for (int r = 0; r < 6; r++) bus_wr(AW'(r*4), 32'h0);
    bus_wr(8'h1C, 32'hA5A5_0F0F);
    bus_wr(8'h20, 32'h03C3_3C3C);
    check_pins("R8 input ignores set");
    bus_wr(8'h28, 32'h0000_00FF);
    check_pins("R8 input ignores clear");
    for (int r = 0; r < 6; r++) bus_wr(AW'(r*4), 32'h0924_9249); // all output
    check_pins("R8 output shows last set/clear");
    check_val("R8 pin0-31 value", out[31:0], 32'hA5A5_0F00);

    // R6/R7: zero bits have no effect; upper word sets pin 57
    bus_wr(8'h1C, 32'h0);
    bus_wr(8'h28, 32'h0);
    check_pins("R6 R7 zero write no effect");
    bus_wr(8'h20, 32'h0200_0000);
    check_val("R6 pin57 set", {31'b0, out[57]}, 32'h1);
    bus_wr(8'h2C, 32'h0200_0000);
    check_val("R7 pin57 clear", {31'b0, out[57]}, 32'h0);
    bus_wr(8'h2C, 32'hFFFF_FFFF);
    check_pins("R7 clear upper word");

    // R9: write-only and unmapped reads, unmapped/unaligned writes
    bus_rd(8'h1C, "R9 set read 0");
    bus_rd(8'h2C, "R9 clr read 0");
    bus_rd(8'h18, "R9 gap read 0");
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_wr(8'h01, 32'hFFFF_FFFF);
    bus_wr(8'h1D, 32'hFFFF_FFFF);
    bus_rd(8'h00, "R9 unaligned ignored");
    check_pins("R9 unmapped writes ignored");

    // R10: no request, no effect
    @(negedge clk);
    req = 0; we = 1; addr = 8'h1C; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    addr = 8'h00; #1;
    check_val("R10 rdata without req", rdata, 32'h0);
    @(negedge clk);
    we = 0; #1;
    check_pins("R10 write without req ignored");
    bus_rd(8'h00, "R10 fsel unchanged");

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 6;
      case (op)
        0: bus_wr(AW'(($urandom % 6) * 4), $urandom);
        1: bus_wr(AW'(8'h1C + ($urandom % 2) * 4), $urandom);
        2: bus_wr(AW'(8'h28 + ($urandom % 2) * 4), $urandom);
        3: bus_rd(AW'(($urandom % 14) * 4), "R2 R9 random read");
        4: set_alt_random();
        default: bus_wr(AW'($urandom), $urandom);
      endcase
      check_pins("R3 R4 R6 R7 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule